// File: doc/BRIEF.md
# Dual-Mode Three-Wire Control Receiver

This block is a write-only serial control slave. It takes register writes from an external controller over three pins: a latch/frame strobe, a bit clock and a serial data line. It never drives anything back onto those pins. The three pins are treated as asynchronous. A faster system clock passes them through synchronizers, and every edge is detected inside the system clock domain. The system clock must run at least four times faster than the bit clock.

The framing mode is chosen from the strobe level at the moment reset is released, and that choice holds until the next reset. In the plain mode a frame is sixteen bits, sent most significant bit first, and the rising edge of the strobe commits it. In the multi-drop mode several slaves share the wires. The strobe rises after an 8-bit device address and falls after a 16-bit payload. Both the address and the payload are sent least significant bit first. A slave writes only when the latched device address equals its own address input.

Every accepted frame appears as a single-cycle write pulse, together with a 7-bit register address and a 9-bit data word. The register file that consumes these writes is outside this block.

Top module: `tw_ctrl_rx`

## Requirements
- R1: In the first system clock cycle after rst_n goes high, the synchronized strobe level selects the mode: high selects plain, low selects multi-drop. The mode holds until the next reset.
- R2: The data line is shifted in only on a rising edge of the synchronized bit clock. Data changes near falling edges are never captured.
- R3: In plain mode the payload is the last 16 bits shifted in, most significant bit first. Payload bits 15..9 give wr_addr and bits 8..0 give wr_data. Any earlier bits are dropped.
- R4: In plain mode only a strobe rising edge issues a write. A strobe falling edge, or a strobe held high, issues none.
- R5: In multi-drop mode, on a strobe rising edge the last 8 bits shifted in are taken as the device address, with the first bit received as address bit 0. They are compared with own_dev_addr.
- R6: In multi-drop mode, on a strobe falling edge the last 16 bits are reordered so that the first bit received becomes payload bit 0. If the address compared on the preceding rising edge matched, a write is issued, split as in R3.
- R7: In multi-drop mode, a falling edge whose preceding address did not match issues no write. wr_addr and wr_data keep their previous values.
- R8: wr_pulse is high for exactly one system clock per accepted frame. wr_addr and wr_data change only together with a pulse and hold their values between pulses.
- R9: While rst_n is low, all outputs are zero and any partially received bits are cleared. A frame started before reset contributes nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release also captures the mode |
| strb_pin | input | 1 | Frame/latch strobe pin (asynchronous) |
| bclk_pin | input | 1 | Serial bit clock pin (asynchronous) |
| sdat_pin | input | 1 | Serial data pin (asynchronous) |
| own_dev_addr | input | 8 | This slave's device address for multi-drop mode |
| wr_pulse | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 9 | Register data of the write |

## Verification
The bench sends plain frames preceded by surplus leading bits. A receiver that counted bits instead of keeping a sliding window would commit the wrong word. The bench also uses a device address whose bit reversal differs from the slave's own address, and sends that reversed value as well. A receiver that shifted the address most significant bit first would either miss the matching frame or accept the reversed one. Reset is applied partway through a frame, followed by a short frame. Stale bits that survived reset would show up in the upper data bits. Every stretch where the strobe sits high, and every strobe edge that must not write, runs against a scoreboard that flags any unexpected pulse. That exposes a receiver that treats the strobe as a level or writes on the wrong edge for the mode.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;

    localparam int unsigned REGADDR_W   = 7;
    localparam int unsigned REGDATA_W   = 9;
    localparam int unsigned DEVADDR_W   = 8;
    localparam int unsigned SYNC_STAGES = 2;

    // positions of the pins inside the synchronized pin vector
    localparam int unsigned PIN_STRB = 0;
    localparam int unsigned PIN_BCLK = 1;
    localparam int unsigned PIN_SDAT = 2;
    localparam int unsigned PIN_CNT  = 3;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_MULTI = 1'b1
    } link_mode_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t stage_d;
    chain_t stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], din};
    end

    // left without reset so that the pin levels are valid when reset is released
    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/tw_edge.sv
module tw_edge #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic         armed;
        logic [W-1:0] prev;
    } edge_t;

    edge_t edge_d;
    edge_t edge_q;

    always_comb begin
        edge_d       = edge_q;
        edge_d.armed = 1'b1;
        edge_d.prev  = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    // no edges are reported until a reference level has been captured
    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise[g] = edge_q.armed &  lvl[g] & ~edge_q.prev[g];
        assign fall[g] = edge_q.armed & ~lvl[g] &  edge_q.prev[g];
    end

endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         lsb_first,
    input  logic         din,
    output logic [W-1:0] word
);

    logic [W-1:0] shift_d;
    logic [W-1:0] shift_q;

    always_comb begin
        shift_d = shift_q;
        if (en) begin
            if (lsb_first) shift_d = {din, shift_q[W-1:1]};
            else           shift_d = {shift_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign word = shift_q;

    AST_SHIFT_ONLY_ON_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(shift_q)); // R2

endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
    import tw_ctrl_pkg::*;
#(
    parameter int unsigned P_REGADDR_W = REGADDR_W,
    parameter int unsigned P_REGDATA_W = REGDATA_W,
    parameter int unsigned P_DEVADDR_W = DEVADDR_W,
    parameter int unsigned P_SYNC      = SYNC_STAGES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strb_pin,
    input  logic                   bclk_pin,
    input  logic                   sdat_pin,
    input  logic [P_DEVADDR_W-1:0] own_dev_addr,
    output logic                   wr_pulse,
    output logic [P_REGADDR_W-1:0] wr_addr,
    output logic [P_REGDATA_W-1:0] wr_data
);

    localparam int unsigned PAYLOAD_W = P_REGADDR_W + P_REGDATA_W;
    localparam int unsigned DEV_TOP   = PAYLOAD_W - 1;
    localparam int unsigned EDGE_W    = PIN_BCLK + 1;

    typedef struct packed {
        logic                   started;
        link_mode_e             mode;
        logic                   match;
        logic                   pulse;
        logic [P_REGADDR_W-1:0] addr;
        logic [P_REGDATA_W-1:0] data;
    } ctl_t;

    logic [PIN_CNT-1:0]   pins_raw;
    logic [PIN_CNT-1:0]   pins_sync;
    logic [EDGE_W-1:0]    edge_rise;
    logic [EDGE_W-1:0]    edge_fall;
    logic                 strb_rise;
    logic                 strb_fall;
    logic                 bclk_rise;
    logic                 unused_bclk_fall;
    logic [PAYLOAD_W-1:0] payload;
    ctl_t                 ctl_d;
    ctl_t                 ctl_q;

    assign pins_raw[PIN_STRB] = strb_pin;
    assign pins_raw[PIN_BCLK] = bclk_pin;
    assign pins_raw[PIN_SDAT] = sdat_pin;

    tw_sync #(.W(PIN_CNT), .STAGES(P_SYNC)) sync_i (
        .clk  (clk),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    tw_edge #(.W(EDGE_W)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pins_sync[EDGE_W-1:0]),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    assign strb_rise        = edge_rise[PIN_STRB];
    assign strb_fall        = edge_fall[PIN_STRB];
    assign bclk_rise        = edge_rise[PIN_BCLK];
    assign unused_bclk_fall = edge_fall[PIN_BCLK];

    tw_shift #(.W(PAYLOAD_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (bclk_rise & ctl_q.started),
        .lsb_first (ctl_q.mode == MODE_MULTI),
        .din       (pins_sync[PIN_SDAT]),
        .word      (payload)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        if (!ctl_q.started) begin
            ctl_d.started = 1'b1;
            ctl_d.mode    = pins_sync[PIN_STRB] ? MODE_PLAIN : MODE_MULTI;
        end else if (ctl_q.mode == MODE_PLAIN) begin
            if (strb_rise) begin
                ctl_d.pulse = 1'b1;
                ctl_d.addr  = payload[PAYLOAD_W-1:P_REGDATA_W];
                ctl_d.data  = payload[P_REGDATA_W-1:0];
            end
        end else begin
            if (strb_rise) begin
                ctl_d.match = (payload[DEV_TOP -: P_DEVADDR_W] == own_dev_addr);
            end
            if (strb_fall) begin
                if (ctl_q.match) begin
                    ctl_d.pulse = 1'b1;
                    ctl_d.addr  = payload[PAYLOAD_W-1:P_REGDATA_W];
                    ctl_d.data  = payload[P_REGDATA_W-1:0];
                end
                ctl_d.match = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_pulse = ctl_q.pulse;
    assign wr_addr  = ctl_q.addr;
    assign wr_data  = ctl_q.data;

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.started && $past(ctl_q.started)) |-> $stable(ctl_q.mode)); // R1
    AST_PLAIN_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && ctl_q.mode == MODE_PLAIN) |-> $past(strb_rise)); // R4
    AST_MULTI_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && ctl_q.mode == MODE_MULTI) |-> $past(strb_fall)); // R6
    AST_MULTI_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && ctl_q.mode == MODE_MULTI) |-> $past(ctl_q.match)); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R8
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data))); // R8

endmodule

// File: tb/tw_ctrl_rx_tb.sv
module tw_ctrl_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strb_pin = 1'b1;
    logic       bclk_pin = 1'b0;
    logic       sdat_pin = 1'b0;
    logic [7:0] own_dev_addr = 8'hC5;
    logic       wr_pulse;
    logic [6:0] wr_addr;
    logic [8:0] wr_data;

    int tests_run = 0;
    int tests_failed = 0;

    typedef struct {
        logic [6:0] a;
        logic [8:0] d;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #4 clk = ~clk; // 125 MHz

    tw_ctrl_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strb_pin     (strb_pin),
        .bclk_pin     (bclk_pin),
        .sdat_pin     (sdat_pin),
        .own_dev_addr (own_dev_addr),
        .wr_pulse     (wr_pulse),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic strb_lvl);
        rst_n    = 1'b0;
        strb_pin = strb_lvl;
        bclk_pin = 1'b0;
        wait_cyc(6);
        check(wr_pulse == 0 && wr_addr == 0 && wr_data == 0, "R9", "outputs in reset",
              {wr_pulse, wr_addr, wr_data}, 0);
        rst_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic send_bit(logic b);
        sdat_pin = b;
        wait_cyc(4);
        bclk_pin = 1'b1;
        wait_cyc(4);
        bclk_pin = 1'b0;
        sdat_pin = ~b; // toggled at the falling edge, must not be captured
    endtask

    // plain frame: nbits sent MSB first, then strobe rises
    task automatic plain_frame(logic [31:0] bits, int nbits, logic [6:0] ea, logic [8:0] ed, string tag);
        exp_t e;
        strb_pin = 1'b0;
        wait_cyc(4);
        for (int i = nbits - 1; i >= 0; i--) send_bit(bits[i]);
        wait_cyc(4);
        e.a = ea; e.d = ed; e.tag = tag;
        exp_q.push_back(e);
        strb_pin = 1'b1;
        wait_cyc(8);
    endtask

    // multi-drop frame: device address then payload, both LSB first
    task automatic md_frame(logic [7:0] dev, logic [6:0] a, logic [8:0] d, bit expect_wr, string tag);
        logic [15:0] w;
        exp_t e;
        w = {a, d};
        for (int i = 0; i < 8; i++) send_bit(dev[i]);
        wait_cyc(4);
        strb_pin = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < 16; i++) send_bit(w[i]);
        wait_cyc(4);
        if (expect_wr) begin
            e.a = a; e.d = d; e.tag = tag;
            exp_q.push_back(e);
        end
        strb_pin = 1'b0;
        wait_cyc(8);
    endtask

    // monitor: every pulse must match the oldest expected write
    always @(negedge clk) begin
        if (rst_n && wr_pulse) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R7", "unexpected write", {wr_addr, wr_data}, 0);
            end else begin
                cur = exp_q.pop_front();
                check(wr_addr == cur.a, cur.tag, "wr_addr", int'(wr_addr), int'(cur.a));
                check(wr_data == cur.d, cur.tag, "wr_data", int'(wr_data), int'(cur.d));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        // plain mode selected by a high strobe at reset release (R1)
        do_reset(1'b1);
        check(wr_pulse == 0 && wr_data == 0, "R9", "outputs after release", wr_data, 0);
        plain_frame({16'h0, 7'h2B, 9'h1F0}, 16, 7'h2B, 9'h1F0, "R3");
        plain_frame({16'h0, 7'h7F, 9'h000}, 16, 7'h7F, 9'h000, "R1");
        // surplus leading bits are dropped (R3)
        plain_frame({12'h0, 4'hF, 7'h01, 9'h155}, 20, 7'h01, 9'h155, "R3");
        // strobe held high: no repeat write (R4), outputs hold (R8)
        wait_cyc(30);
        check(exp_q.size() == 0, "R4", "pending writes", exp_q.size(), 0);
        check(wr_addr == 7'h01 && wr_data == 9'h155, "R8", "held data", wr_data, 9'h155);

        // partial frame then reset: stale bits discarded (R9)
        strb_pin = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        do_reset(1'b1);
        check(wr_data == 0 && wr_addr == 0, "R9", "outputs cleared", wr_data, 0);
        plain_frame({26'h0, 6'b101101}, 6, 7'h00, 9'h02D, "R9");

        // multi-drop mode selected by a low strobe at reset release (R1)
        do_reset(1'b0);
        md_frame(8'hC5, 7'h12, 9'h0AB, 1'b1, "R6");
        // bit-reversed own address must not match (R5, R7)
        md_frame(8'hA3, 7'h33, 9'h111, 1'b0, "R7");
        check(wr_addr == 7'h12 && wr_data == 9'h0AB, "R7", "held after mismatch", wr_data, 9'h0AB);
        md_frame(8'hC5, 7'h55, 9'h1C3, 1'b1, "R5");
        md_frame(8'h00, 7'h01, 9'h001, 1'b0, "R7");
        check(wr_addr == 7'h55 && wr_data == 9'h1C3, "R7", "held after mismatch 2", wr_data, 9'h1C3);

        // back to plain mode after a new reset (R1)
        do_reset(1'b1);
        plain_frame({16'h0, 7'h40, 9'h0F0}, 16, 7'h40, 9'h0F0, "R1");
        wait_cyc(20);
        check(exp_q.size() == 0, "R6", "writes missing at end", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule